// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port behind a byte-wide register bus. Each pin has its own direction bit: a 1 drives the pad from the output latch, a 0 leaves the pad as an input whose level is passed through a two-flop synchronizer before software can see it.

The output latch is not reached at a single address. Any word-aligned offset from 0x000 to 0x3FC selects the data port, and address bits [9:2] of that offset act as a pin mask in which bit n selects pin n. A write changes only the latch bits whose mask bit is 1, so one store can set or clear a single pin without a read-modify-write. A read returns the live pin levels in the masked positions and 0 elsewhere. The direction register sits at offset 0x400. The bus has no back-pressure: every access completes in the cycle it is presented, and read data appears on `bus_rdata` one clock later. Control and pad pins are plain levels.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction register and output latch are all zeros, so `pad_oe`, `pad_out` and `bus_rdata` are 0.
- R2: A write to offset 0x400 loads the direction register from `bus_wdata` (bit n is pin n, 1 = output); `pad_oe` equals it from the next cycle, and a read of 0x400 returns it.
- R3: A write to a data offset (offset[11:10] = 0, offset[1:0] = 0) updates latch bit n from `bus_wdata[n]` only where offset bit n+2 is 1; other latch bits keep their value. `pad_out` equals the latch.
- R4: A read of a data offset returns, in each position whose mask bit (offset bit n+2) is 1, the latch bit for an output pin; unmasked positions read 0.
- R5: An input pin reads its pad level through a two-stage synchronizer: a pad change made just before a read is not visible to reads returned at the next two clock edges, and is visible at the third.
- R6: Offsets other than the data window and 0x400 (including data offsets with offset[1:0] not 0) read as 0 and writes to them change neither `pad_out` nor `pad_oe`.
- R7: `bus_rdata` is registered: it carries the read value in the cycle after `bus_re` is sampled high and is 0 after a cycle with `bus_re` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Raw pad levels, asynchronous |
| pad_out | output | 8 | Pad drive values (output latch) |
| pad_oe | output | 8 | Pad output enables (direction bits) |

## Verification
The bench sweeps all 256 masks for both writes and reads, once with every pin an output and once with a mixed direction pattern, so a design that decoded the mask from the wrong address bits or wrote unmasked latch bits would corrupt neighbouring pins and be caught against the arithmetic model. Reads with a mixed direction catch a design that returned the latch for input pins or leaked unmasked bits. A pad change is read at three consecutive edges, so a synchronizer with one or three stages shows the new value at the wrong read. Writes to 0x401, 0x404, 0x800 and the misaligned offset 0x3FD catch decoding that ignores low or high address bits.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
  typedef enum logic [1:0] {
    AREA_NONE = 2'd0,
    AREA_DATA = 2'd1,
    AREA_DIR  = 2'd2
  } area_e;
endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
  import gpio_mp_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output area_e             area_o,
  output logic [NPINS-1:0]  mask_o
);
  localparam int MASK_LO = 2;
  localparam int MASK_HI = NPINS + MASK_LO - 1;
  localparam logic [ADDR_W-1:0] DIR_OFS = ADDR_W'(1) << (MASK_HI + 1);

  logic above_window;
  logic misaligned;

  assign above_window = |addr_i[ADDR_W-1:MASK_HI+1];
  assign misaligned   = |addr_i[MASK_LO-1:0];
  assign mask_o       = addr_i[MASK_HI:MASK_LO];

  always_comb begin
    if (addr_i == DIR_OFS)                   area_o = AREA_DIR;
    else if (!above_window && !misaligned)   area_o = AREA_DATA;
    else                                     area_o = AREA_NONE;
  end
endmodule

// File: rtl/gpio_mp_regs.sv
module gpio_mp_regs
  import gpio_mp_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  area_e            area_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] latch_o
);
  logic dir_we;
  logic data_we;

  assign dir_we  = we_i && (area_i == AREA_DIR);
  assign data_we = we_i && (area_i == AREA_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_o <= '0;
    else if (dir_we) dir_o <= wdata_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     latch_o[p] <= 1'b0;
      else if (data_we && mask_i[p])  latch_o[p] <= wdata_i[p];
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mp_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  area_e            area;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] pad_sync;
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] rd_value;

  gpio_mp_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr),
    .area_o (area),
    .mask_o (mask)
  );

  gpio_mp_regs #(.NPINS(NPINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we),
    .area_i  (area),
    .mask_i  (mask),
    .wdata_i (bus_wdata),
    .dir_o   (dir_q),
    .latch_o (latch_q)
  );

  gpio_mp_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (pad_sync)
  );

  assign level = (dir_q & latch_q) | (~dir_q & pad_sync);

  always_comb begin
    unique case (area)
      AREA_DATA: rd_value = level & mask;
      AREA_DIR:  rd_value = dir_q;
      default:   rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_value;
    else             bus_rdata <= '0;
  end

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_mp_checker.sv
module gpio_mp_checker #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe
);
  localparam logic [ADDR_W-1:0] DIR_AT = ADDR_W'(1) << (NPINS + 2);

  logic             hit_dir;
  logic             hit_data;
  logic [NPINS-1:0] amask;

  assign hit_dir  = (bus_addr == DIR_AT);
  assign hit_data = (bus_addr < DIR_AT) && (bus_addr[1:0] == 2'b00);
  assign amask    = bus_addr[NPINS+1:2];

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (pad_out == '0 && pad_oe == '0 && bus_rdata == '0); // R1
    end
  end

  AST_OE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && hit_dir |=> pad_oe == $past(bus_wdata)); // R2
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && hit_dir) |=> $stable(pad_oe)); // R2
  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && hit_data |=> (pad_out & $past(amask)) == ($past(bus_wdata) & $past(amask))); // R3
  AST_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && hit_data |=> ((pad_out ^ $past(pad_out)) & ~$past(amask)) == '0); // R3
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && hit_data) |=> $stable(pad_out)); // R6
  AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && hit_data |=> (bus_rdata & ~$past(amask)) == '0); // R4
  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !hit_data && !hit_dir |=> bus_rdata == '0); // R6
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0); // R7
endmodule

bind gpio_mask_port gpio_mp_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe)
);

// File: tb/gpio_mask_port_bench.sv
module gpio_mask_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_latch = '0;
  logic [7:0] model_dir = '0;

  always #5 clk = ~clk;

  gpio_mask_port u_gpio_mask_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] data_at(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [7:0] v;
    logic [7:0] oe_keep;
    logic [7:0] out_keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h400, r); check("R1 dir read", r, 8'h00);

    // R2 direction register
    wr(12'h400, 8'hFF); model_dir = 8'hFF;
    check("R2 pad_oe", pad_oe, 8'hFF);
    rd(12'h400, r); check("R2 dir read", r, 8'hFF);

    // R3/R4 sweep all masks with every pin an output
    for (int m = 0; m < 256; m++) begin
      v = 8'((m * 37 + 11) & 8'hFF);
      wr(data_at(8'(m)), v);
      model_latch = (model_latch & ~8'(m)) | (v & 8'(m));
      check("R3 pad_out", pad_out, model_latch);
      rd(data_at(8'(m)), r);
      check("R4 read", r, model_latch & 8'(m));
    end

    // R3 single-pin set and clear
    wr(data_at(8'hFF), 8'h00); model_latch = 8'h00;
    wr(data_at(8'h08), 8'hFF); model_latch = 8'h08;
    check("R3 set pin3", pad_out, model_latch);
    wr(data_at(8'h08), 8'h00); model_latch = 8'h00;
    check("R3 clear pin3", pad_out, model_latch);
    wr(data_at(8'hFF), 8'h3C); model_latch = 8'h3C;

    // R7 rdata returns to 0 after the read cycle
    rd(data_at(8'hFF), r); check("R4 full read", r, 8'h3C);
    @(negedge clk); check("R7 idle rdata", bus_rdata, 8'h00);

    // R2/R4/R5 mixed direction, masked reads of inputs
    wr(12'h400, 8'hA5); model_dir = 8'hA5;
    check("R2 pad_oe mixed", pad_oe, 8'hA5);
    pad_in = 8'h96;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 256; m++) begin
      rd(data_at(8'(m)), r);
      check("R4 mixed read", r, ((model_dir & model_latch) | (~model_dir & pad_in)) & 8'(m));
    end

    // R5 synchronizer latency: two reads old, third new
    @(negedge clk);
    pad_in = 8'h69;
    bus_addr = data_at(8'hFF); bus_re = 1'b1;
    @(negedge clk); r = bus_rdata;
    check("R5 edge1", r, (model_dir & model_latch) | (~model_dir & 8'h96));
    @(negedge clk); r = bus_rdata;
    check("R5 edge2", r, (model_dir & model_latch) | (~model_dir & 8'h96));
    @(negedge clk); r = bus_rdata;
    check("R5 edge3", r, (model_dir & model_latch) | (~model_dir & 8'h69));
    bus_re = 1'b0;
    @(negedge clk);

    // R6 unmapped offsets
    oe_keep = pad_oe; out_keep = pad_out;
    for (int k = 0; k < 4; k++) begin
      logic [11:0] a;
      case (k)
        0: a = 12'h401;
        1: a = 12'h404;
        2: a = 12'h800;
        default: a = 12'h3FD;
      endcase
      wr(a, 8'h5A);
      check("R6 pad_out kept", pad_out, out_keep);
      check("R6 pad_oe kept", pad_oe, oe_keep);
      rd(a, r);
      check("R6 read zero", r, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule